// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block runs the hardware side of a software-requested change of the system clock source. Software picks a new source by writing a 3-bit code into a next-source field and then setting a start bit. Each write is accepted only in the cycle right after its own unlock strobe. The sequencer first drops requests that are redundant or illegal. For a legal request it turns on the target oscillator. It then waits for the crystal start-up timer and for PLL lock when the target needs them, and counts rising edges of the new clock until it is settled. Only then does it move a one-hot mux select, using break-before-make so that two sources are never selected at once. On completion it copies the code into the current-source field and clears the start bit. From then on the old oscillator is switched off, unless a keep-alive condition still holds it.

There are four physical oscillators: the fast internal RC, the primary source, the secondary low-power crystal and the low-power internal RC. Six source codes map onto them, and two of those codes run through the PLL. A configuration input hard-disables the whole mechanism, and that input defaults to 1. While it is set, the current source simply follows a configuration source-select input. All control and status pins are plain levels or single-cycle strobes. The block has no streaming interface, so no back-pressure rules apply.

Top module: `clk_source_switch`

## Requirements
- R1: Source codes: 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 secondary crystal, 5 low-power RC; codes 6 and 7 are invalid. Physical index: fast RC 0, primary 1, secondary 2, low-power RC 3. After a synchronous active-low reset, the current-source and next-source fields equal `cfg_src`. The start bit, `lock_flag` and `cf_flag` are 0, and `clk_sel` is the one-hot of the physical index of `cfg_src`.
- R2: While `cfg_sw_disable` is 1, the start bit reads 0 and writes have no effect. The current-source field follows `cfg_src` one cycle later, and the fail-safe keep-alive of the low-power RC is off.
- R3: A write to the next-source field (`wr_hi`) takes effect only in the cycle right after `unlock_hi`. A write to the start bit (`wr_lo`) takes effect only in the cycle right after `unlock_lo`. A write at any other time is dropped.
- R4: If the start bit is set and the next-source code equals the current-source code, the start bit clears one cycle later and nothing else changes.
- R5: `cf_event` sets `cf_flag`. A valid request clears both `lock_flag` and `cf_flag` in the cycle the switch begins.
- R6: Before a switch to the secondary crystal completes, `ost_sec` must be high. Before a switch to the primary completes, `ost_pri` must be high, unless `cfg_pri_mode` is 2 (external clock). While the sequencer waits, the select and the current source stay unchanged and the target is already enabled.
- R7: A switch to code 1 or 3 waits for `pll_lock_in` and then sets `lock_flag`.
- R8: After the target is ready, at least `SETTLE_CYC` (default 10) rising edges of the target clock occur before the select changes. The select passes through all-zero for at least one cycle and never jumps from one source to another.
- R9: On completion the start bit clears, the current source takes the next-source code, and `clk_sel` shows the new source.
- R10: `src_en` enables the current source and, during a switch, the target. The low-power RC also stays enabled while `wdt_en` or (`cfg_fscm_en` and switching enabled) is 1. The secondary crystal also stays enabled while `sosc_keep` is 1. Every other source is disabled.
- R11: A request from code 1 to code 3 or from code 3 to code 1 is rejected, and so is a request for code 6 or 7. Rejection clears the start bit and leaves the current source unchanged.
- R12: While a request is pending or a switch is in progress, writes to the next-source field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sw_disable | input | 1 | 1 disables clock switching and fail-safe monitoring |
| cfg_src | input | 3 | Configured start-up source code |
| cfg_pri_mode | input | 2 | Primary submode: 0 crystal, 1 high-speed crystal, 2 external clock |
| cfg_fscm_en | input | 1 | Fail-safe monitor enable |
| wdt_en | input | 1 | Watchdog enabled |
| sosc_keep | input | 1 | Software keep-alive for the secondary crystal |
| unlock_hi | input | 1 | Unlock strobe for the next-source write |
| unlock_lo | input | 1 | Unlock strobe for the start-bit write |
| wr_hi | input | 1 | Next-source write strobe |
| wr_lo | input | 1 | Start-bit write strobe |
| wr_nsrc | input | 3 | Next-source write data |
| wr_swen | input | 1 | Start-bit write data |
| ost_pri | input | 1 | Primary start-up timer expired |
| ost_sec | input | 1 | Secondary start-up timer expired |
| pll_lock_in | input | 1 | PLL lock indication |
| cf_event | input | 1 | Clock-fail detection strobe |
| src_clk_raw | input | 4 | Raw oscillator clocks by physical index |
| cur_src | output | 3 | Current-source code |
| nxt_src | output | 3 | Next-source code |
| swen | output | 1 | Start bit |
| lock_flag | output | 1 | PLL-lock status flag |
| cf_flag | output | 1 | Clock-fail status flag |
| busy | output | 1 | Switch in progress |
| src_en | output | 4 | Oscillator enables by physical index |
| clk_sel | output | 4 | One-hot clock mux select |

## Verification
The bench uses the default `SETTLE_CYC` of 10 and a two-stage synchronizer. Each raw oscillator runs at its own period, between 5 and 17 controller cycles. With those values, the edge count before a switch to the slowest oscillator can be measured against a tight window. A full random walk over all six codes also stays short enough to cover many redundant, rejected and PLL-bound requests.

// File: rtl/cksw_pkg.sv
package cksw_pkg;
  localparam int NPH = 4;
  typedef logic [2:0] src_code_t;

  localparam src_code_t C_FRC     = 3'd0;
  localparam src_code_t C_FRC_PLL = 3'd1;
  localparam src_code_t C_PRI     = 3'd2;
  localparam src_code_t C_PRI_PLL = 3'd3;
  localparam src_code_t C_SEC     = 3'd4;
  localparam src_code_t C_LPRC    = 3'd5;

  localparam logic [1:0] PH_FRC  = 2'd0;
  localparam logic [1:0] PH_PRI  = 2'd1;
  localparam logic [1:0] PH_SEC  = 2'd2;
  localparam logic [1:0] PH_LPRC = 2'd3;

  localparam logic [1:0] PRI_EXT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WPLL, S_SETTLE, S_BREAK
  } seq_state_t;

  function automatic logic [1:0] phys_of(src_code_t c);
    case (c)
      C_FRC, C_FRC_PLL: return PH_FRC;
      C_PRI, C_PRI_PLL: return PH_PRI;
      C_SEC:            return PH_SEC;
      C_LPRC:           return PH_LPRC;
      default:          return PH_FRC;
    endcase
  endfunction

  function automatic logic needs_pll(src_code_t c);
    return (c == C_FRC_PLL) || (c == C_PRI_PLL);
  endfunction

  function automatic logic code_valid(src_code_t c);
    return c <= C_LPRC;
  endfunction

  function automatic logic pll_conflict(src_code_t a, src_code_t b);
    return ((a == C_FRC_PLL) && (b == C_PRI_PLL)) ||
           ((a == C_PRI_PLL) && (b == C_FRC_PLL));
  endfunction

  function automatic logic [NPH-1:0] onehot_of(logic [1:0] p);
    logic [NPH-1:0] r;
    r = '0;
    r[p] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/cksw_sync.sv
module cksw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cksw_settle.sv
module cksw_settle #(
  parameter int SETTLE_CYC  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tgt_clk_raw,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic          tclk_s;
  logic          tclk_d;
  logic [CW-1:0] cnt;
  logic          rise;

  cksw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tgt_clk_raw),
    .q_sync  (tclk_s)
  );

  assign rise = tclk_s & ~tclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tclk_d <= 1'b0;
      cnt    <= '0;
    end else begin
      tclk_d <= tclk_s;
      if (!enable)
        cnt <= '0;
      else if (rise && cnt != LIMIT)
        cnt <= cnt + 1'b1;
    end
  end

  assign done = enable && (cnt == LIMIT);
endmodule

// File: rtl/cksw_seq.sv
module cksw_seq
  import cksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sw_disable,
  input  src_code_t  cfg_src,
  input  logic [1:0] cfg_pri_mode,
  input  logic       unlock_hi,
  input  logic       unlock_lo,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  src_code_t  wr_nsrc,
  input  logic       wr_swen,
  input  logic       ost_pri,
  input  logic       ost_sec,
  input  logic       pll_lock_in,
  input  logic       cf_event,
  input  logic       settle_done,
  output src_code_t  cur_src,
  output src_code_t  nxt_src,
  output logic       swen,
  output logic       lock_flag,
  output logic       cf_flag,
  output logic       busy,
  output logic       settling,
  output logic       breaking
);
  seq_state_t state;
  logic hi_open, lo_open;
  logic acc_hi, acc_lo;
  logic redundant, rejected, tgt_ready;

  assign busy     = (state != S_IDLE);
  assign settling = (state == S_SETTLE);
  assign breaking = (state == S_BREAK);

  // next-source is frozen once a request is pending; start bit once busy
  assign acc_hi = wr_hi & hi_open & ~busy & ~swen & ~cfg_sw_disable;
  assign acc_lo = wr_lo & lo_open & ~busy & ~cfg_sw_disable;

  always_comb begin
    redundant = (nxt_src == cur_src);
    rejected  = !code_valid(nxt_src) || pll_conflict(cur_src, nxt_src);
    case (phys_of(nxt_src))
      PH_PRI:  tgt_ready = (cfg_pri_mode == PRI_EXT) || ost_pri;
      PH_SEC:  tgt_ready = ost_sec;
      default: tgt_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_src   <= cfg_src;
      nxt_src   <= cfg_src;
      swen      <= 1'b0;
      lock_flag <= 1'b0;
      cf_flag   <= 1'b0;
      hi_open   <= 1'b0;
      lo_open   <= 1'b0;
    end else begin
      hi_open <= unlock_hi;
      lo_open <= unlock_lo;
      if (cf_event) cf_flag <= 1'b1;
      if (cfg_sw_disable) begin
        state   <= S_IDLE;
        cur_src <= cfg_src;
        nxt_src <= cfg_src;
        swen    <= 1'b0;
      end else begin
        if (acc_hi) nxt_src <= wr_nsrc;
        if (acc_lo) swen    <= wr_swen;
        case (state)
          S_IDLE: begin
            if (swen) begin
              if (redundant || rejected) begin
                swen <= 1'b0;
              end else begin
                lock_flag <= 1'b0;
                cf_flag   <= 1'b0;
                state     <= S_START;
              end
            end
          end
          S_START: begin
            if (tgt_ready) state <= needs_pll(nxt_src) ? S_WPLL : S_SETTLE;
          end
          S_WPLL: begin
            if (pll_lock_in) begin
              lock_flag <= 1'b1;
              state     <= S_SETTLE;
            end
          end
          S_SETTLE: begin
            if (settle_done) state <= S_BREAK;
          end
          S_BREAK: begin
            cur_src <= nxt_src;
            swen    <= 1'b0;
            state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import cksw_pkg::*;
#(
  parameter int SETTLE_CYC  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sw_disable,
  input  logic [2:0] cfg_src,
  input  logic [1:0] cfg_pri_mode,
  input  logic       cfg_fscm_en,
  input  logic       wdt_en,
  input  logic       sosc_keep,
  input  logic       unlock_hi,
  input  logic       unlock_lo,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [2:0] wr_nsrc,
  input  logic       wr_swen,
  input  logic       ost_pri,
  input  logic       ost_sec,
  input  logic       pll_lock_in,
  input  logic       cf_event,
  input  logic [3:0] src_clk_raw,
  output logic [2:0] cur_src,
  output logic [2:0] nxt_src,
  output logic       swen,
  output logic       lock_flag,
  output logic       cf_flag,
  output logic       busy,
  output logic [3:0] src_en,
  output logic [3:0] clk_sel
);
  logic settling, breaking, settle_done;
  logic tgt_raw;
  logic fscm_eff;

  cksw_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_sw_disable (cfg_sw_disable),
    .cfg_src        (cfg_src),
    .cfg_pri_mode   (cfg_pri_mode),
    .unlock_hi      (unlock_hi),
    .unlock_lo      (unlock_lo),
    .wr_hi          (wr_hi),
    .wr_lo          (wr_lo),
    .wr_nsrc        (wr_nsrc),
    .wr_swen        (wr_swen),
    .ost_pri        (ost_pri),
    .ost_sec        (ost_sec),
    .pll_lock_in    (pll_lock_in),
    .cf_event       (cf_event),
    .settle_done    (settle_done),
    .cur_src        (cur_src),
    .nxt_src        (nxt_src),
    .swen           (swen),
    .lock_flag      (lock_flag),
    .cf_flag        (cf_flag),
    .busy           (busy),
    .settling       (settling),
    .breaking       (breaking)
  );

  assign tgt_raw = src_clk_raw[phys_of(nxt_src)];

  cksw_settle #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_settle (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (settling),
    .tgt_clk_raw (tgt_raw),
    .done        (settle_done)
  );

  assign fscm_eff = cfg_fscm_en & ~cfg_sw_disable;

  // break-before-make: all-zero select during the break state
  assign clk_sel = breaking ? '0 : onehot_of(phys_of(cur_src));

  for (genvar g = 0; g < NPH; g++) begin : g_en
    logic keep;
    if (g == int'(PH_LPRC)) begin : g_lp
      assign keep = wdt_en | fscm_eff;
    end else if (g == int'(PH_SEC)) begin : g_sc
      assign keep = sosc_keep;
    end else begin : g_no
      assign keep = 1'b0;
    end
    assign src_en[g] = (phys_of(cur_src) == 2'(g)) |
                       (busy && (phys_of(nxt_src) == 2'(g))) | keep;
  end
endmodule

// File: rtl/clk_source_switch_chk.sv
module clk_source_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_sw_disable,
  input logic [2:0] cur_src,
  input logic [2:0] nxt_src,
  input logic       swen,
  input logic       lock_flag,
  input logic       cf_flag,
  input logic       busy,
  input logic [3:0] clk_sel
);
  a_r2_start_bit_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sw_disable |-> !swen);

  a_r4_redundant_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (swen && !busy && !cfg_sw_disable && nxt_src == cur_src) |=> (!swen && !busy));

  a_r5_flags_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!lock_flag && !cf_flag));

  a_r8_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_sel));

  a_r8_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sw_disable && !$past(cfg_sw_disable) && clk_sel != 4'd0 && $past(clk_sel) != 4'd0)
      |-> (clk_sel == $past(clk_sel)));

  a_r9_commit_copies_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!swen && cur_src == nxt_src));

  a_r12_next_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_sw_disable) |=> $stable(nxt_src));
endmodule

bind clk_source_switch clk_source_switch_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_sw_disable (cfg_sw_disable),
  .cur_src        (cur_src),
  .nxt_src        (nxt_src),
  .swen           (swen),
  .lock_flag      (lock_flag),
  .cf_flag        (cf_flag),
  .busy           (busy),
  .clk_sel        (clk_sel)
);

// File: tb/clk_source_switch_test.sv
`timescale 1ns/1ps
module clk_source_switch_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic r0 = 0, r1 = 0, r2 = 0, r3 = 0;
  always #50  r0 = ~r0;
  always #70  r1 = ~r1;
  always #130 r2 = ~r2;
  always #170 r3 = ~r3;

  logic rst_n, cfg_sw_disable, cfg_fscm_en, wdt_en, sosc_keep;
  logic [2:0] cfg_src, wr_nsrc;
  logic [1:0] cfg_pri_mode;
  logic unlock_hi, unlock_lo, wr_hi, wr_lo, wr_swen;
  logic ost_pri, ost_sec, pll_lock_in, cf_event;
  logic [2:0] cur_src, nxt_src;
  logic swen, lock_flag, cf_flag, busy;
  logic [3:0] src_en, clk_sel;

  clk_source_switch uut (
    .clk(clk), .rst_n(rst_n), .cfg_sw_disable(cfg_sw_disable), .cfg_src(cfg_src),
    .cfg_pri_mode(cfg_pri_mode), .cfg_fscm_en(cfg_fscm_en), .wdt_en(wdt_en),
    .sosc_keep(sosc_keep), .unlock_hi(unlock_hi), .unlock_lo(unlock_lo),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_nsrc(wr_nsrc), .wr_swen(wr_swen),
    .ost_pri(ost_pri), .ost_sec(ost_sec), .pll_lock_in(pll_lock_in),
    .cf_event(cf_event), .src_clk_raw({r3, r2, r1, r0}),
    .cur_src(cur_src), .nxt_src(nxt_src), .swen(swen), .lock_flag(lock_flag),
    .cf_flag(cf_flag), .busy(busy), .src_en(src_en), .clk_sel(clk_sel)
  );

  int e3 = 0;
  always @(posedge r3) e3 = e3 + 1;

  int checks = 0, fails = 0, jumps = 0;
  bit saw_zero = 0;
  logic [3:0] prev_sel = 4'd0;
  bit mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_sel != 0 && clk_sel != 0 && prev_sel != clk_sel) jumps++;
      if (clk_sel == 0) saw_zero = 1;
    end
    prev_sel = clk_sel;
  end

  function automatic int phys(int c);
    if (c <= 1) return 0;
    if (c <= 3) return 1;
    if (c == 4) return 2;
    return 3;
  endfunction

  function automatic logic [3:0] exp_en(int c, bit wdt, bit fs, bit dis, bit keep);
    logic [3:0] r;
    r = 4'd0;
    r[phys(c)] = 1'b1;
    if (wdt || (fs && !dis)) r[3] = 1'b1;
    if (keep) r[2] = 1'b1;
    return r;
  endfunction

  function automatic bit is_valid(int cur, int nx);
    if (nx > 5 || nx == cur) return 0;
    if ((cur == 1 && nx == 3) || (cur == 3 && nx == 1)) return 0;
    return 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit dis, int src);
    rst_n = 0; cfg_sw_disable = dis; cfg_src = 3'(src);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write_hi(int code, bit unlock);
    unlock_hi = unlock; @(negedge clk); unlock_hi = 0;
    wr_hi = 1; wr_nsrc = 3'(code); @(negedge clk); wr_hi = 0;
  endtask

  task automatic write_lo(bit v, bit unlock);
    unlock_lo = unlock; @(negedge clk); unlock_lo = 0;
    wr_lo = 1; wr_swen = v; @(negedge clk); wr_lo = 0;
  endtask

  task automatic request(int code);
    write_hi(code, 1);
    write_lo(1, 1);
  endtask

  task automatic wait_idle(string req);
    int n;
    n = 0;
    while (swen && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, req, "switch did not finish", n, 3000);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int s, model_cur, code;
    bit w, f, k;
    void'($urandom(32'd4711));
    unlock_hi = 0; unlock_lo = 0; wr_hi = 0; wr_lo = 0; wr_nsrc = 0; wr_swen = 0;
    ost_pri = 1; ost_sec = 1; pll_lock_in = 1; cf_event = 0;
    cfg_pri_mode = 0; cfg_fscm_en = 0; wdt_en = 0; sosc_keep = 0;
    do_reset(0, 0);

    // R1 reset state
    chk(cur_src == 0 && nxt_src == 0, "R1", "reset source", cur_src, 0);
    chk(!swen && !lock_flag && !cf_flag && !busy, "R1", "reset flags", {swen, lock_flag, cf_flag}, 0);
    chk(clk_sel == 4'b0001, "R1", "reset select", clk_sel, 1);
    chk(src_en == 4'b0001, "R10", "reset enables", src_en, 1);

    // R3 locked writes
    write_hi(5, 0);
    chk(nxt_src == 0, "R3", "hi write without unlock", nxt_src, 0);
    unlock_hi = 1; @(negedge clk); unlock_hi = 0; @(negedge clk);
    wr_hi = 1; wr_nsrc = 5; @(negedge clk); wr_hi = 0;
    chk(nxt_src == 0, "R3", "hi write one cycle late", nxt_src, 0);
    write_lo(1, 0);
    chk(!swen, "R3", "lo write without unlock", swen, 0);
    write_hi(5, 1);
    chk(nxt_src == 5, "R3", "unlocked hi write", nxt_src, 5);

    // R4 redundant
    write_hi(0, 1);
    write_lo(1, 1);
    @(negedge clk);
    chk(!swen && !busy && cur_src == 0, "R4", "redundant abort", {swen, busy}, 0);

    // R8/R9/R10 switch to low-power RC
    mon_on = 1; saw_zero = 0;
    s = e3;
    request(5);
    wait_idle("R9");
    chk((e3 - s) >= 10 && (e3 - s) <= 14, "R8", "target edges before switch", e3 - s, 10);
    chk(saw_zero, "R8", "zero select seen", saw_zero, 1);
    chk(cur_src == 5 && clk_sel == 4'b1000, "R9", "commit to LPRC", cur_src, 5);
    chk(src_en == 4'b1000, "R10", "old FRC off", src_en, 8);

    // R10 watchdog keep
    wdt_en = 1;
    request(0); wait_idle("R10");
    chk(src_en == 4'b1001, "R10", "LPRC kept by watchdog", src_en, 9);
    wdt_en = 0; @(negedge clk);
    chk(src_en == 4'b0001, "R10", "LPRC released", src_en, 1);

    // R5 clock fail flag
    cf_event = 1; @(negedge clk); cf_event = 0;
    chk(cf_flag, "R5", "cf set", cf_flag, 1);

    // R6 crystal start-up wait, R12 busy ignore
    ost_pri = 0; cfg_pri_mode = 0;
    request(2);
    repeat (60) @(negedge clk);
    chk(busy && cur_src == 0 && clk_sel == 4'b0001, "R6", "wait for start-up", cur_src, 0);
    chk(src_en == 4'b0011, "R6", "target enabled while waiting", src_en, 3);
    chk(!cf_flag, "R5", "cf cleared on start", cf_flag, 0);
    write_hi(4, 1);
    chk(nxt_src == 2, "R12", "write ignored while busy", nxt_src, 2);
    ost_pri = 1;
    wait_idle("R6");
    chk(cur_src == 2, "R6", "primary reached", cur_src, 2);

    // R7 PLL wait
    pll_lock_in = 0;
    request(3);
    repeat (60) @(negedge clk);
    chk(busy && !lock_flag && cur_src == 2, "R7", "wait for lock", {busy, lock_flag}, 2);
    pll_lock_in = 1;
    wait_idle("R7");
    chk(lock_flag && cur_src == 3, "R7", "lock flag and commit", cur_src, 3);

    // R11 rejections
    request(1); @(negedge clk);
    chk(!swen && !busy && cur_src == 3, "R11", "PLL to PLL rejected", cur_src, 3);
    request(6); @(negedge clk);
    chk(!swen && !busy && cur_src == 3, "R11", "invalid code rejected", cur_src, 3);

    // R6 external submode needs no start-up timer
    request(0); wait_idle("R6");
    ost_pri = 0; cfg_pri_mode = 2;
    request(2); wait_idle("R6");
    chk(cur_src == 2, "R6", "external clock no wait", cur_src, 2);
    ost_pri = 1; cfg_pri_mode = 0;

    // R10 secondary keep-alive
    sosc_keep = 1;
    request(4); wait_idle("R10");
    request(0); wait_idle("R10");
    chk(src_en == 4'b0101, "R10", "secondary kept", src_en, 5);
    sosc_keep = 0; @(negedge clk);
    chk(src_en == 4'b0001, "R10", "secondary released", src_en, 1);

    // random walk
    model_cur = 0;
    for (int i = 0; i < 40; i++) begin
      code = int'($urandom_range(0, 7));
      w = 1'($urandom_range(0, 1)); f = 1'($urandom_range(0, 1)); k = 1'($urandom_range(0, 1));
      wdt_en = w; cfg_fscm_en = f; sosc_keep = k;
      cfg_pri_mode = 2'($urandom_range(0, 2));
      request(code);
      wait_idle("R9");
      if (is_valid(model_cur, code)) model_cur = code;
      chk(cur_src == 3'(model_cur), (code > 5) ? "R11" : "R9", "random cur", cur_src, model_cur);
      chk(clk_sel == 4'(1 << phys(model_cur)), "R9", "random select", clk_sel, 1 << phys(model_cur));
      chk(src_en == exp_en(model_cur, w, f, 0, k), "R10", "random enables", src_en,
          exp_en(model_cur, w, f, 0, k));
    end
    wdt_en = 0; sosc_keep = 0;
    chk(jumps == 0, "R8", "direct select jumps", jumps, 0);
    mon_on = 0;

    // R2 disabled mode
    cfg_fscm_en = 1;
    do_reset(1, 5);
    chk(cur_src == 5 && clk_sel == 4'b1000, "R2", "config source", cur_src, 5);
    request(0); @(negedge clk);
    chk(!swen && cur_src == 5 && clk_sel == 4'b1000, "R2", "request no effect", cur_src, 5);
    cfg_src = 2; @(negedge clk);
    chk(cur_src == 2, "R2", "follows config", cur_src, 2);
    chk(src_en == 4'b0010, "R2", "fail-safe keep off", src_en, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule